// File: doc/BRIEF.md
# Synchronous Serial Master Transceiver with Gated Clock Output

This block sends 8-bit words on a serial data line in the usual asynchronous frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It also drives a serial clock that follows those data bits. The clock toggles only inside the data-bit positions of a frame. It rests at its idle level during the start bit, during the stop bit and while the line is idle. Clock polarity and phase are programmable, and an option keeps or drops the clock pulse on the final data bit.

The receiver has no oversampling. It takes the receive line once per data bit, at the clock's sampling edge in the middle of the bit. Clocks are produced only while a word is being sent, so a word is received only while one is being transmitted. The usual use is a full-duplex exchange with a clocked peripheral, where each word written also collects one word back.

Configuration (polarity, phase, last-bit clock and the half-bit divider) is captured only while `enable` is low. Internally, a frame state machine steps through four states:
- IDLE: on a pending word with the block enabled, it goes to START.
- START: at the end of the bit, it goes to DATA.
- DATA: at the end of bit 7, it goes to STOP.
- STOP: at the end of the bit, it goes to START if another word is pending, otherwise to IDLE.

Dropping `enable` takes any state to IDLE.

Top module: `sync_usart_master`

## Requirements
- R1: While idle, `tx` is 1. A frame drives `tx` to 0 for the start bit, then data bits 0 to 7, then 1 for the stop bit. Each bit lasts 2*(half_div+1) clock cycles, split into a first half and a second half of half_div+1 cycles each. `tx` changes only at bit boundaries.
- R2: `sclk` equals the latched polarity value when the block is idle, during the start bit and during the stop bit.
- R3: During each data bit, `sclk` holds the inverse of the latched polarity for exactly one half-bit. With phase 0 this is the second half; with phase 1 it is the first half. The sampling edge is therefore always at mid-bit, and the data change always falls on the opposite edge.
- R4: With the last-bit clock option set to 1 a frame has 8 clock pulses. With it set to 0 the pulse for data bit 7 is dropped and the frame has 7 pulses.
- R5: With `rx_en` = 1, `rx` is taken at the middle of each data bit and assembled least significant bit first. At the last sample, `rd_data` takes the word and `rx_full` becomes 1. A cycle with `rd_ack` = 1 clears `rx_full`, unless a new word completes in that same cycle.
- R6: With `rx_en` = 0, no bits are captured, and both `rx_full` and `rd_data` stay unchanged across the whole frame.
- R7: A write (`wr_valid` = 1) is accepted only when `enable` = 1 and `tx_empty` = 1. Acceptance clears `tx_empty`. `tx_empty` returns to 1 in the cycle when the word moves into the shift register at frame start. A write while `tx_empty` = 0 is dropped.
- R8: A frame starts only when `enable` = 1, `tx_en` = 1 and a word is pending. If a word is pending when a stop bit ends, the next start bit follows immediately, with no idle cycle.
- R9: Polarity, phase, last-bit clock and `half_div` are captured on every clock edge while `enable` = 0. Changes to them while `enable` = 1 have no effect on `sclk`, `tx` or bit timing.
- R10: Dropping `enable` aborts any frame and discards a pending word. `tx` returns to 1, `sclk` returns to its idle level and `tx_empty` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; configuration is captured while low |
| tx_en | input | 1 | Allows new frames to start |
| rx_en | input | 1 | Allows received bits to be captured |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: pulse in second half of a bit, 1: pulse in first half |
| cfg_last_clk | input | 1 | 1: pulse on data bit 7, 0: no pulse on data bit 7 |
| half_div | input | 16 | Half-bit length minus one, in clock cycles |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Word to transmit |
| tx_empty | output | 1 | Holding register free |
| rd_ack | input | 1 | Read strobe; clears `rx_full` |
| rd_data | output | 8 | Last received word |
| rx_full | output | 1 | Received word waiting |
| tx | output | 1 | Serial data out |
| rx | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock out |

## Verification
The assertions assume that `half_div` is at least 1. They also assume that `rx` is stable for at least one cycle around the mid-bit sampling point, which stands in for the required setup and hold margin of one sixteenth of a bit. The stimulus meets both conditions by feeding `tx` straight back into `rx` and using divider values of 1 to 3. Inputs change only on falling clock edges. Configuration changes are made with `enable` low, apart from the one case that checks they are ignored. `rx_en` is held constant across each frame.

// File: rtl/usart_sync_pkg.sv
package usart_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } frame_state_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic last_clk;
    } clk_cfg_t;

endpackage

// File: rtl/usart_cfg_latch.sv
module usart_cfg_latch
    import usart_sync_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  clk_cfg_t         cfg_in,
    input  logic [DIV_W-1:0] div_in,
    output clk_cfg_t         cfg_q,
    output logic [DIV_W-1:0] div_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_in;
            div_q <= div_in;
        end
    end

    // R9: settings frozen while enabled
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> ($stable(cfg_q) && $stable(div_q)));

endmodule

// File: rtl/usart_bit_timer.sv
module usart_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             half_tick,
    output logic             phase,
    output logic             bit_end
);

    logic [DIV_W-1:0] cnt_q;

    assign half_tick = run && (cnt_q == half_div);
    assign bit_end   = half_tick && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (half_tick) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: half-bit counter never passes its limit while running
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> (cnt_q <= half_div));

endmodule

// File: rtl/usart_rx_capture.sv
module usart_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              last_bit,
    input  logic              rx_en,
    input  logic              rx,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full
);

    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_next;
    logic              take;

    assign take       = sample && rx_en;
    assign shift_next = {rx, shift_q[DATA_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            rd_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (take) begin
                shift_q <= shift_next;
            end
            if (take && last_bit) begin
                rd_data <= shift_next;
                rx_full <= 1'b1;
            end else if (rd_ack) begin
                rx_full <= 1'b0;
            end
        end
    end

    // R5: a new word appears only after the final sample
    assert_full_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(sample && last_bit));

    // R6: no capture when receiving is disabled
    assert_rx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(rd_data));

endmodule

// File: rtl/usart_frame_fsm.sv
module usart_frame_fsm
    import usart_sync_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_en,
    input  clk_cfg_t          cfg,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              half_tick,
    input  logic              phase,
    input  logic              bit_end,
    output logic              run,
    output logic              sample,
    output logic              last_bit,
    output logic              tx_empty,
    output logic              tx,
    output logic              sclk
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    frame_state_t      state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic              start_ok;
    logic              load;
    logic              pulse;

    assign start_ok = enable && tx_en && !tx_empty;
    assign run      = (state_q != ST_IDLE);
    assign last_bit = (idx_q == LAST_IDX);
    assign sample   = half_tick && !phase && (state_q == ST_DATA);
    assign load     = (state_d == ST_START) && (state_q != ST_START);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_START;
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA:  if (bit_end && last_bit) state_d = ST_STOP;
            ST_STOP:  if (bit_end) state_d = start_ok ? ST_START : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // holding and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            shift_q  <= '0;
            idx_q    <= '0;
            tx_empty <= 1'b1;
        end else if (!enable) begin
            tx_empty <= 1'b1;
            idx_q    <= '0;
        end else begin
            if (load) begin
                shift_q  <= hold_q;
                idx_q    <= '0;
                tx_empty <= 1'b1;
            end else if (wr_valid && tx_empty) begin
                hold_q   <= wr_data;
                tx_empty <= 1'b0;
            end
            if (state_q == ST_DATA && bit_end) begin
                shift_q <= shift_q >> 1;
                idx_q   <= last_bit ? '0 : idx_q + 1'b1;
            end
        end
    end

    // output process: registered pins
    always_comb begin
        pulse = (state_q == ST_DATA) && (!last_bit || cfg.last_clk)
                && (cfg.cpha ? !phase : phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx   <= 1'b1;
            sclk <= 1'b0;
        end else begin
            unique case (state_q)
                ST_START: tx <= 1'b0;
                ST_DATA:  tx <= shift_q[0];
                default:  tx <= 1'b1;
            endcase
            sclk <= cfg.cpol ^ pulse;
        end
    end

    // R2: clock rests outside data bits
    assert_sclk_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DATA) |=> (sclk == $past(cfg.cpol)));

    // R1: start bit drives the line low
    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |=> (tx == 1'b0));

    // R7: holding register fills only on an accepted write
    assert_fill_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_valid && enable));

    // R10: disable empties the holding register
    assert_abort_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> tx_empty);

endmodule

// File: rtl/sync_usart_master.sv
module sync_usart_master
    import usart_sync_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_last_clk,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              tx,
    input  logic              rx,
    output logic              sclk
);

    clk_cfg_t         cfg_in, cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             run, half_tick, phase, bit_end, sample, last_bit;

    assign cfg_in = '{cpol: cfg_cpol, cpha: cfg_cpha, last_clk: cfg_last_clk};

    usart_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .cfg_in (cfg_in),
        .div_in (half_div),
        .cfg_q  (cfg_q),
        .div_q  (div_q)
    );

    usart_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half_div  (div_q),
        .half_tick (half_tick),
        .phase     (phase),
        .bit_end   (bit_end)
    );

    usart_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tx_en     (tx_en),
        .cfg       (cfg_q),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .half_tick (half_tick),
        .phase     (phase),
        .bit_end   (bit_end),
        .run       (run),
        .sample    (sample),
        .last_bit  (last_bit),
        .tx_empty  (tx_empty),
        .tx        (tx),
        .sclk      (sclk)
    );

    usart_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .last_bit (last_bit),
        .rx_en    (rx_en),
        .rx       (rx),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .rx_full  (rx_full)
    );

endmodule

// File: tb/sim_sync_usart_master.sv
`timescale 1ns/1ps
module sim_sync_usart_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, tx_en = 1'b1, rx_en = 1'b1;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_last_clk = 1'b1;
    logic [15:0] half_div = 16'd1;
    logic       wr_valid = 1'b0, rd_ack = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_empty, rx_full, tx, sclk;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    sync_usart_master u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_last_clk(cfg_last_clk),
        .half_div(half_div), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_empty(tx_empty), .rd_ack(rd_ack), .rd_data(rd_data), .rx_full(rx_full),
        .tx(tx), .rx(tx), .sclk(sclk)
    );

    int checks = 0, fails = 0, cycles = 0;

    // behavioural reference model
    bit       m_act, m_full, m_cpol, m_cpha, m_last;
    int       m_pos, m_div;
    bit [7:0] m_cur, m_hold;
    bit       e_tx = 1, e_sclk = 0, e_txe = 1, e_rxf = 0;
    bit [7:0] e_rdata = 0;

    always @(posedge clk) begin
        int per, b, r;
        bit h, was_full;
        if (!rst_n) begin
            m_act = 0; m_full = 0; m_cpol = 0; m_cpha = 0; m_last = 0; m_div = 0;
            e_tx = 1; e_sclk = 0; e_rxf = 0; e_rdata = 0; e_txe = 1;
        end else begin
            per = 2 * (m_div + 1);
            if (m_act) begin
                b = m_pos / per;
                r = m_pos % per;
                h = (r > m_div);
                e_tx = (b == 0) ? 1'b0 : (b <= 8) ? m_cur[b-1] : 1'b1;
                e_sclk = m_cpol ^ ((b >= 1) && (b <= 8) && ((b < 8) || m_last)
                                   && (m_cpha ? !h : h));
                if (rx_en && m_pos == 8 * per + m_div) begin
                    e_rxf = 1; e_rdata = m_cur;
                end else if (rd_ack) e_rxf = 0;
            end else begin
                e_tx = 1; e_sclk = m_cpol;
                if (rd_ack) e_rxf = 0;
            end
            was_full = m_full;
            if (!enable) begin
                m_act = 0; m_full = 0;
                m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_last = cfg_last_clk;
                m_div = half_div;
            end else begin
                if (m_act) begin
                    if (m_pos == 10 * per - 1) begin
                        if (m_full && tx_en) begin
                            m_cur = m_hold; m_full = 0; m_pos = 0;
                        end else m_act = 0;
                    end else m_pos++;
                end else if (m_full && tx_en) begin
                    m_act = 1; m_pos = 0; m_cur = m_hold; m_full = 0;
                end
                if (wr_valid && !was_full) begin
                    m_hold = wr_data; m_full = 1;
                end
            end
            e_txe = !m_full;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison and clock edge counting
    int  edges = 0;
    bit  prev_sclk = 0, lat_cpol = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1", "tx", tx, e_tx);
            check("R3", "sclk", sclk, e_sclk);
            check("R7", "tx_empty", tx_empty, e_txe);
            check("R5", "rx_full", rx_full, e_rxf);
            check("R5", "rd_data", rd_data, e_rdata);
            if (sclk != prev_sclk && sclk != lat_cpol) edges++;
        end
        prev_sclk = sclk;
    end

    task automatic configure(bit pol, bit pha, bit lst, int dv);
        @(negedge clk);
        enable = 0; cfg_cpol = pol; cfg_cpha = pha; cfg_last_clk = lst; half_div = 16'(dv);
        @(negedge clk);
        @(negedge clk);
        lat_cpol = pol;
        enable = 1;
    endtask

    task automatic write_word(bit [7:0] d);
        @(negedge clk);
        wr_valid = 1; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_ack();
        @(negedge clk);
        rd_ack = 1;
        @(negedge clk);
        rd_ack = 0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state R1 R2 R5 R7
        check("R1", "reset tx", tx, 1);
        check("R2", "reset sclk", sclk, 0);
        check("R7", "reset tx_empty", tx_empty, 1);
        check("R5", "reset rx_full", rx_full, 0);

        // all clock modes, last-bit pulse on and off R3 R4 R5
        for (int m = 0; m < 8; m++) begin
            bit [7:0] d;
            d = 8'hA5 ^ 8'(m * 37);
            configure(m[0], m[1], m[2], 1 + (m % 3));
            edges = 0;
            write_word(d);
            wait_cycles(10 * 2 * (2 + (m % 3)) + 6);
            check("R4", "pulses per frame", edges, m[2] ? 8 : 7);
            check("R5", "loopback word", rd_data, d);
            check("R5", "rx_full set", rx_full, 1);
            read_ack();
            check("R5", "rx_full cleared", rx_full, 0);
        end

        // R9: config changes while enabled are ignored
        configure(0, 0, 1, 1);
        cfg_cpol = 1; cfg_cpha = 1; cfg_last_clk = 0; half_div = 16'd3;
        edges = 0;
        write_word(8'h3C);
        wait_cycles(46);
        check("R9", "pulses with frozen config", edges, 8);
        check("R9", "sclk idle level kept", sclk, 0);
        read_ack();

        // R6: receiver off keeps word and flag
        configure(1, 0, 1, 1);
        rx_en = 0;
        write_word(8'hF0);
        wait_cycles(46);
        check("R6", "rx_full untouched", rx_full, 0);
        check("R6", "rd_data untouched", rd_data, 8'h3C);
        rx_en = 1;

        // R8 R7: back-to-back frames and dropped write
        write_word(8'h81);
        write_word(8'h42);
        write_word(8'hFF);
        check("R7", "holding busy", tx_empty, 0);
        wait_cycles(90);
        check("R8", "second word received", rd_data, 8'h42);
        read_ack();

        // R8: transmitter disabled, no frame
        tx_en = 0;
        write_word(8'h55);
        wait_cycles(30);
        check("R8", "no start without tx_en", tx_empty, 0);
        tx_en = 1;
        wait_cycles(46);
        read_ack();

        // R10: abort mid-frame
        write_word(8'h00);
        wait_cycles(12);
        @(negedge clk);
        enable = 0;
        wait_cycles(3);
        check("R10", "tx idle after abort", tx, 1);
        check("R10", "sclk idle after abort", sclk, cfg_cpol);
        check("R10", "tx_empty after abort", tx_empty, 1);

        wait_cycles(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule